// File: doc/BRIEF.md
# Instrument Status Register Set

This block gathers status for an instrument controller. Three groups of flags feed it: operation, questionable and standard event. Every group keeps a condition register that samples the incoming flags each clock. It also keeps an event register that catches rising edges of those flags, and an enable mask. An event bit stays set until software reads the event register. The read returns the bits and clears them in one step.

Each group turns its enabled events into one summary bit inside an 8-bit status byte. A message-available flag also appears in that byte. A service-request enable register selects which status byte bits raise the request-service bit and the service-request output.

Software reaches all registers through a small register-mapped port. Read data appears one clock after the read strobe. A write to a dedicated preset address clears the three group enable masks in one operation.

Top module: `status_reg_set`

## Requirements
- R1: The operation condition register (address 0) and the standard event condition register (address 6) read back the condition input as it was sampled on the clock edge before the read.
- R2: An event bit is set only when its condition bit was 0 in the condition register and is 1 on the input at a clock edge. It stays set after the condition returns to 0. Event registers are at addresses 1 (operation), 4 (questionable) and 7 (standard event).
- R3: A read of an event register returns its current value and clears that register to zero.
- R4: When a rising condition edge arrives in the same clock as a clearing read of that event register, the read returns the old value and the new event bit remains set afterwards.
- R5: The enable masks are readable and writable at addresses 2 (operation), 5 (questionable) and 8 (standard event). A group's summary bit is 1 exactly when some bit is set in both its event register and its enable mask.
- R6: In the status byte, bit 7 is the operation summary, bit 5 is the standard event summary, bit 4 follows the message-available input directly, bit 3 is the questionable summary, and bits 2..0 are 0. The status byte can also be read at address 10, zero-extended.
- R7: The service-request enable register (address 9, 8 bits, read/write) selects status byte bits. Bit 6 of the status byte and the service-request output are 1 exactly when some status byte bit other than bit 6 is set together with its enable bit.
- R8: The questionable condition and event registers always read 0 and its summary is always 0. Its enable mask still accepts writes and reads them back.
- R9: Any write to address 11 clears the three group enable masks. It leaves the condition registers, the event registers and the service-request enable unchanged.
- R10: Reset clears all condition, event, enable and service-request enable registers and the read data. The status byte then equals only the message-available bit.
- R11: Read data is registered: it changes only on the clock edge of a read strobe and otherwise holds. Addresses 12..15 read as 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_cond_in | input | COND_W | Raw operation condition flags |
| se_cond_in | input | COND_W | Raw standard event condition flags |
| msg_avail | input | 1 | Message available flag |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| addr | input | 4 | Register address |
| wdata | input | COND_W | Write data |
| rdata | output | COND_W | Registered read data |
| status_byte | output | 8 | Summary status byte |
| srq | output | 1 | Service request |

## Verification
A lost or spurious event bit shows at the ports as a status byte summary that is wrong on the clock after the edge. It also shows as a wrong value from the next event read. Both can be seen within two clocks of the fault. A clear-on-read that fails, or that swallows a same-cycle edge, shows on the very next read of that register. A bad enable or service-request mask flips a status byte bit or the service-request line combinationally, in the cycle after the write. The bench compares every output against a reference model on every clock, so any of these faults is caught in the cycle it first reaches a port.

// File: rtl/status_pkg.sv
package status_pkg;
   typedef enum logic [3:0] {
      A_OP_COND  = 4'd0,
      A_OP_EV    = 4'd1,
      A_OP_EN    = 4'd2,
      A_QU_COND  = 4'd3,
      A_QU_EV    = 4'd4,
      A_QU_EN    = 4'd5,
      A_SE_COND  = 4'd6,
      A_SE_EV    = 4'd7,
      A_SE_EN    = 4'd8,
      A_SRE      = 4'd9,
      A_STB      = 4'd10,
      A_PRESET   = 4'd11
   } reg_addr_e;

   localparam int unsigned STB_W = 8;
endpackage

// File: rtl/status_group.sv
module status_group #(
   parameter int unsigned W        = 16,
   parameter bit          HAS_COND = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] cond_in,
   input  logic         en_we,
   input  logic [W-1:0] en_wd,
   input  logic         en_preset,
   input  logic         ev_rd,
   output logic [W-1:0] cond_q,
   output logic [W-1:0] ev_q,
   output logic [W-1:0] en_q,
   output logic         summary
);
   localparam logic [W-1:0] LIVE = HAS_COND ? {W{1'b1}} : {W{1'b0}};

   if (W < 1) begin : g_bad_w
      $error("status_group: W must be at least 1");
   end

   logic [W-1:0] c_r, e_r, m_r;
   logic [W-1:0] rise;

   // positive-edge transition filter against the condition register
   assign rise = cond_in & ~c_r & LIVE;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         c_r <= '0;
         e_r <= '0;
      end else begin
         c_r <= cond_in & LIVE;
         // a new edge survives a clearing read in the same cycle (R4)
         e_r <= (ev_rd ? '0 : e_r) | rise;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         m_r <= '0;
      else if (en_preset) m_r <= '0;
      else if (en_we)     m_r <= en_wd;
   end

   assign cond_q  = c_r;
   assign ev_q    = e_r;
   assign en_q    = m_r;
   assign summary = |(e_r & m_r);
endmodule

// File: rtl/status_byte_unit.sv
module status_byte_unit #(
   parameter int unsigned OP_POS  = 7,
   parameter int unsigned RQS_POS = 6,
   parameter int unsigned SE_POS  = 5,
   parameter int unsigned MAV_POS = 4,
   parameter int unsigned QU_POS  = 3
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       sre_we,
   input  logic [7:0] sre_wd,
   input  logic       op_sum,
   input  logic       se_sum,
   input  logic       qu_sum,
   input  logic       mav,
   output logic [7:0] sre_q,
   output logic [7:0] stb,
   output logic       srq
);
   logic [7:0] raw;
   logic [7:0] sre_r;
   logic       req;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      sre_r <= '0;
      else if (sre_we) sre_r <= sre_wd;
   end

   for (genvar b = 0; b < 8; b++) begin : g_raw
      if (b == OP_POS) begin : g_op
         assign raw[b] = op_sum;
      end else if (b == SE_POS) begin : g_se
         assign raw[b] = se_sum;
      end else if (b == MAV_POS) begin : g_mav
         assign raw[b] = mav;
      end else if (b == QU_POS) begin : g_qu
         assign raw[b] = qu_sum;
      end else begin : g_zero
         assign raw[b] = 1'b0;
      end
   end

   assign req = |(raw & sre_r);

   for (genvar b = 0; b < 8; b++) begin : g_out
      if (b == RQS_POS) begin : g_rqs
         assign stb[b] = req;
      end else begin : g_pass
         assign stb[b] = raw[b];
      end
   end

   assign sre_q = sre_r;
   assign srq   = req;
endmodule

// File: rtl/status_reg_set.sv
module status_reg_set
   import status_pkg::*;
#(
   parameter int unsigned COND_W  = 16,
   parameter int unsigned OP_POS  = 7,
   parameter int unsigned RQS_POS = 6,
   parameter int unsigned SE_POS  = 5,
   parameter int unsigned MAV_POS = 4,
   parameter int unsigned QU_POS  = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [COND_W-1:0] op_cond_in,
   input  logic [COND_W-1:0] se_cond_in,
   input  logic              msg_avail,
   input  logic              rd_en,
   input  logic              wr_en,
   input  logic [3:0]        addr,
   input  logic [COND_W-1:0] wdata,
   output logic [COND_W-1:0] rdata,
   output logic [7:0]        status_byte,
   output logic              srq
);
   localparam logic [7:0] POS_SET = 8'((1 << OP_POS) | (1 << RQS_POS) | (1 << SE_POS)
                                     | (1 << MAV_POS) | (1 << QU_POS));

   if (COND_W < STB_W || COND_W > 32) begin : g_bad_width
      $error("status_reg_set: COND_W must lie in 8..32");
   end
   if (OP_POS > 7 || RQS_POS > 7 || SE_POS > 7 || MAV_POS > 7 || QU_POS > 7) begin : g_bad_pos
      $error("status_reg_set: status byte positions must lie in 0..7");
   end
   if ($countones(POS_SET) != 5) begin : g_dup_pos
      $error("status_reg_set: status byte positions must be distinct");
   end

   logic [COND_W-1:0] op_cond_q, op_ev_q, op_en_q;
   logic [COND_W-1:0] se_cond_q, se_ev_q, se_en_q;
   logic [COND_W-1:0] qu_cond_q, qu_ev_q, qu_en_q;
   logic              op_sum, se_sum, qu_sum;
   logic [7:0]        sre_q;
   logic              preset_hit;

   assign preset_hit = wr_en && (addr == A_PRESET);

   status_group #(.W(COND_W), .HAS_COND(1'b1)) u_op (
      .clk(clk), .rst_n(rst_n), .cond_in(op_cond_in),
      .en_we(wr_en && addr == A_OP_EN), .en_wd(wdata), .en_preset(preset_hit),
      .ev_rd(rd_en && addr == A_OP_EV),
      .cond_q(op_cond_q), .ev_q(op_ev_q), .en_q(op_en_q), .summary(op_sum));

   status_group #(.W(COND_W), .HAS_COND(1'b1)) u_se (
      .clk(clk), .rst_n(rst_n), .cond_in(se_cond_in),
      .en_we(wr_en && addr == A_SE_EN), .en_wd(wdata), .en_preset(preset_hit),
      .ev_rd(rd_en && addr == A_SE_EV),
      .cond_q(se_cond_q), .ev_q(se_ev_q), .en_q(se_en_q), .summary(se_sum));

   status_group #(.W(COND_W), .HAS_COND(1'b0)) u_qu (
      .clk(clk), .rst_n(rst_n), .cond_in('0),
      .en_we(wr_en && addr == A_QU_EN), .en_wd(wdata), .en_preset(preset_hit),
      .ev_rd(rd_en && addr == A_QU_EV),
      .cond_q(qu_cond_q), .ev_q(qu_ev_q), .en_q(qu_en_q), .summary(qu_sum));

   status_byte_unit #(
      .OP_POS(OP_POS), .RQS_POS(RQS_POS), .SE_POS(SE_POS),
      .MAV_POS(MAV_POS), .QU_POS(QU_POS)
   ) u_stb (
      .clk(clk), .rst_n(rst_n),
      .sre_we(wr_en && addr == A_SRE), .sre_wd(wdata[7:0]),
      .op_sum(op_sum), .se_sum(se_sum), .qu_sum(qu_sum), .mav(msg_avail),
      .sre_q(sre_q), .stb(status_byte), .srq(srq));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdata <= '0;
      end else if (rd_en) begin
         case (addr)
            A_OP_COND: rdata <= op_cond_q;
            A_OP_EV:   rdata <= op_ev_q;
            A_OP_EN:   rdata <= op_en_q;
            A_QU_COND: rdata <= qu_cond_q;
            A_QU_EV:   rdata <= qu_ev_q;
            A_QU_EN:   rdata <= qu_en_q;
            A_SE_COND: rdata <= se_cond_q;
            A_SE_EV:   rdata <= se_ev_q;
            A_SE_EN:   rdata <= se_en_q;
            A_SRE:     rdata <= COND_W'(sre_q);
            A_STB:     rdata <= COND_W'(status_byte);
            default:   rdata <= '0;
         endcase
      end
   end
endmodule

// File: rtl/status_reg_set_chk.sv
module status_reg_set_chk
   import status_pkg::*;
#(
   parameter int unsigned W       = 16,
   parameter int unsigned MAV_POS = 4,
   parameter int unsigned RQS_POS = 6
) (
   input logic         clk,
   input logic         rst_n,
   input logic         rd_en,
   input logic         wr_en,
   input logic [3:0]   addr,
   input logic [W-1:0] op_cond_in,
   input logic [W-1:0] op_cond,
   input logic [W-1:0] op_ev,
   input logic [W-1:0] qu_cond,
   input logic [W-1:0] qu_ev,
   input logic [W-1:0] op_en,
   input logic [W-1:0] se_en,
   input logic [W-1:0] qu_en,
   input logic [7:0]   status_byte,
   input logic         msg_avail,
   input logic         srq
);
   // R2: a rising condition bit is in the event register one clock later
   a_r2_rise_sets: assert property (@(posedge clk) disable iff (!rst_n)
      (|(op_cond_in & ~op_cond)) |=>
      ((op_ev & $past(op_cond_in & ~op_cond)) == $past(op_cond_in & ~op_cond)));

   // R2: without a clearing read, no event bit falls
   a_r2_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      !(rd_en && addr == A_OP_EV) |=> ((op_ev & $past(op_ev)) == $past(op_ev)));

   // R3 and R4: after a clearing read only same-cycle edges remain
   a_r3_clear_on_read: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && addr == A_OP_EV) |=> (op_ev == $past(op_cond_in & ~op_cond)));

   // R8: questionable condition and event stay empty
   a_r8_qu_empty: assert property (@(posedge clk) disable iff (!rst_n)
      (qu_cond == '0) && (qu_ev == '0));

   // R9: preset empties all group masks
   a_r9_preset: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == A_PRESET) |=> (op_en == '0 && se_en == '0 && qu_en == '0));

   // R6: message-available appears directly in the status byte
   a_r6_mav: assert property (@(posedge clk) disable iff (!rst_n)
      status_byte[MAV_POS] == msg_avail);

   // R6: low status byte bits stay zero
   a_r6_low_zero: assert property (@(posedge clk) disable iff (!rst_n)
      status_byte[2:0] == 3'b000);

   // R7: service-request output agrees with the request-service bit
   a_r7_srq_match: assert property (@(posedge clk) disable iff (!rst_n)
      srq == status_byte[RQS_POS]);
endmodule

bind status_reg_set status_reg_set_chk #(.W(COND_W), .MAV_POS(MAV_POS), .RQS_POS(RQS_POS)) u_chk (
   .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .wr_en(wr_en), .addr(addr),
   .op_cond_in(op_cond_in), .op_cond(op_cond_q), .op_ev(op_ev_q),
   .qu_cond(qu_cond_q), .qu_ev(qu_ev_q),
   .op_en(op_en_q), .se_en(se_en_q), .qu_en(qu_en_q),
   .status_byte(status_byte), .msg_avail(msg_avail), .srq(srq));

// File: tb/status_reg_set_test.sv
module status_reg_set_test;
   localparam int W = 16;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [W-1:0] op_cond_in = '0;
   logic [W-1:0] se_cond_in = '0;
   logic         msg_avail = 1'b0;
   logic         rd_en = 1'b0;
   logic         wr_en = 1'b0;
   logic [3:0]   addr = '0;
   logic [W-1:0] wdata = '0;
   logic [W-1:0] rdata;
   logic [7:0]   status_byte;
   logic         srq;

   int checks = 0;
   int errors = 0;
   bit cmp_on = 1'b0;
   bit done = 1'b0;
   int cycles = 0;

   always #5 clk = ~clk;

   status_reg_set uut (
      .clk(clk), .rst_n(rst_n), .op_cond_in(op_cond_in), .se_cond_in(se_cond_in),
      .msg_avail(msg_avail), .rd_en(rd_en), .wr_en(wr_en), .addr(addr),
      .wdata(wdata), .rdata(rdata), .status_byte(status_byte), .srq(srq));

   // ---------------- reference model ----------------
   logic [W-1:0] m_opc, m_ope, m_open, m_sec, m_see, m_seen, m_quen, m_rd;
   logic [7:0]   m_sre;

   function automatic logic [7:0] model_stb(input logic mav);
      logic [7:0] raw;
      logic       req;
      raw    = 8'h00;
      raw[7] = |(m_ope & m_open);
      raw[5] = |(m_see & m_seen);
      raw[4] = mav;
      raw[3] = 1'b0;
      req    = |(raw & m_sre & 8'hBF);
      raw[6] = req;
      return raw;
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_opc = '0; m_ope = '0; m_open = '0;
         m_sec = '0; m_see = '0; m_seen = '0;
         m_quen = '0; m_sre = '0; m_rd = '0;
      end else begin
         logic [W-1:0] rise_op, rise_se;
         if (rd_en) begin
            case (addr)
               4'd0:  m_rd = m_opc;
               4'd1:  m_rd = m_ope;
               4'd2:  m_rd = m_open;
               4'd5:  m_rd = m_quen;
               4'd6:  m_rd = m_sec;
               4'd7:  m_rd = m_see;
               4'd8:  m_rd = m_seen;
               4'd9:  m_rd = W'(m_sre);
               4'd10: m_rd = W'(model_stb(msg_avail));
               default: m_rd = '0;
            endcase
         end
         rise_op = op_cond_in & ~m_opc;
         rise_se = se_cond_in & ~m_sec;
         if (rd_en && addr == 4'd1) m_ope = '0;
         if (rd_en && addr == 4'd7) m_see = '0;
         m_ope = m_ope | rise_op;
         m_see = m_see | rise_se;
         m_opc = op_cond_in;
         m_sec = se_cond_in;
         if (wr_en) begin
            case (addr)
               4'd2:  m_open = wdata;
               4'd5:  m_quen = wdata;
               4'd8:  m_seen = wdata;
               4'd9:  m_sre  = wdata[7:0];
               4'd11: begin m_open = '0; m_seen = '0; m_quen = '0; end
               default: ;
            endcase
         end
      end
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
      end
   endtask

   // every-cycle comparison against the model
   always @(negedge clk) begin
      if (cmp_on && rst_n) begin
         chk("R11 rdata", 32'(rdata), 32'(m_rd));
         chk("R6 status_byte", 32'(status_byte), 32'(model_stb(msg_avail)));
         chk("R7 srq", 32'(srq), 32'(model_stb(msg_avail) >> 6) & 32'd1);
      end
   end

   // watchdog
   always @(posedge clk) begin
      cycles++;
      if (!done && cycles > 150000) begin
         errors++;
         $display("FAIL watchdog expired actual=%0d expected<150000", cycles);
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   // ---------------- stimulus helpers ----------------
   task automatic step();
      @(posedge clk);
      #2;
   endtask

   task automatic do_write(input logic [3:0] a, input logic [W-1:0] d);
      wr_en = 1'b1; addr = a; wdata = d;
      step();
      wr_en = 1'b0;
   endtask

   task automatic do_read(input logic [3:0] a, input logic [W-1:0] exp, input string tag);
      rd_en = 1'b1; addr = a;
      step();
      rd_en = 1'b0;
      chk(tag, 32'(rdata), 32'(exp));
   endtask

   initial begin
      rst_n = 1'b0;
      step(); step();
      // R10: reset state
      chk("R10 status_byte after reset", 32'(status_byte), 32'h0);
      chk("R10 srq after reset", 32'(srq), 32'h0);
      chk("R10 rdata after reset", 32'(rdata), 32'h0);
      rst_n = 1'b1;
      step();
      cmp_on = 1'b1;
      do_read(4'd1, '0, "R10 op event zero");
      do_read(4'd2, '0, "R10 op enable zero");

      // R1: condition readback
      op_cond_in = 16'h00A5;
      step();
      do_read(4'd0, 16'h00A5, "R1 op condition");
      se_cond_in = 16'h0300;
      step();
      do_read(4'd6, 16'h0300, "R1 se condition");

      // R2: events stay after the condition falls
      op_cond_in = 16'h0000;
      step();
      do_read(4'd1, 16'h00A5, "R2 sticky op event");
      // R3: cleared by the read
      do_read(4'd1, 16'h0000, "R3 op event cleared");

      // R5: enable + summary
      do_write(4'd2, 16'h0001);
      do_read(4'd2, 16'h0001, "R5 op enable readback");
      op_cond_in = 16'h0001;
      step();
      chk("R5 op summary in status byte", 32'(status_byte), 32'h80);

      // R7: service request enable
      do_write(4'd9, 16'h0080);
      chk("R7 srq raised", 32'(srq), 32'h1);
      chk("R7 rqs bit", 32'(status_byte), 32'hC0);
      do_read(4'd9, 16'h0080, "R7 sre readback");

      // R6: message available and standard event summary
      msg_avail = 1'b1;
      do_write(4'd8, 16'h0004);
      se_cond_in = 16'h0004;
      step();
      chk("R6 full status byte", 32'(status_byte), 32'hF0);
      do_read(4'd10, 16'h00F0, "R6 status byte read");

      // R4: edge arrives together with a clearing read
      do_read(4'd7, 16'h0304, "R3 se event read");
      se_cond_in = 16'h0000;
      step();
      rd_en = 1'b1; addr = 4'd7; se_cond_in = 16'h0004;
      step();
      rd_en = 1'b0;
      chk("R4 read during edge returns old", 32'(rdata), 32'h0);
      do_read(4'd7, 16'h0004, "R4 edge kept after clear");

      // R8: questionable group
      do_write(4'd5, 16'hFFFF);
      do_read(4'd5, 16'hFFFF, "R8 qu enable readback");
      do_read(4'd3, 16'h0000, "R8 qu condition zero");
      do_read(4'd4, 16'h0000, "R8 qu event zero");
      chk("R8 qu summary bit", 32'(status_byte[3]), 32'h0);

      // R9: preset
      do_write(4'd11, 16'h1234);
      do_read(4'd2, 16'h0000, "R9 op enable cleared");
      do_read(4'd8, 16'h0000, "R9 se enable cleared");
      do_read(4'd5, 16'h0000, "R9 qu enable cleared");
      do_read(4'd9, 16'h0080, "R9 sre kept");
      do_read(4'd0, 16'h0001, "R9 op condition kept");

      // R11: unmapped addresses and hold
      do_write(4'd13, 16'hBEEF);
      do_read(4'd13, 16'h0000, "R11 unmapped reads zero");
      do_read(4'd9, 16'h0080, "R11 sre");
      step(); step();
      chk("R11 rdata holds", 32'(rdata), 32'h0080);

      // randomised run, compared every clock
      for (int i = 0; i < 4000; i++) begin
         int op;
         op_cond_in ^= 16'($urandom & $urandom & $urandom);
         se_cond_in ^= 16'($urandom & $urandom & $urandom);
         msg_avail = 1'($urandom);
         op = $urandom % 8;
         rd_en = (op < 4) || (op == 6);
         wr_en = (op == 4) || (op == 5) || (op == 6);
         addr  = 4'($urandom);
         if (wr_en && addr == 4'd11 && ($urandom % 4 != 0)) addr = 4'd2;
         wdata = 16'($urandom);
         step();
      end
      rd_en = 1'b0; wr_en = 1'b0;

      // R10: reset mid-run clears events and enables
      op_cond_in = '0; se_cond_in = '0; msg_avail = 1'b0;
      cmp_on = 1'b0;
      rst_n = 1'b0;
      step(); step();
      rst_n = 1'b1;
      step();
      cmp_on = 1'b1;
      do_read(4'd1, '0, "R10 op event after reset");
      do_read(4'd7, '0, "R10 se event after reset");
      do_read(4'd9, '0, "R10 sre after reset");
      chk("R10 status byte after reset", 32'(status_byte), 32'h0);

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule